// File: doc/BRIEF.md
# Write-Sharing Push Predictor

This block sits next to one processor's write-back data cache in a multiprocessor that runs speculative threads. It learns which store instructions write lines that another processor later pulls away through a coherence writeback. When such a store executes again, the line it writes is marked. At thread commit each marked line is written back, dropped from the local cache and pushed to a peer cache, so the reader finds the data already there.

Three small tables do the work. A store history records the PC of each recent store in a ring of slots. The cache keeps the slot number of the last store beside each line. A watch list holds the PCs of stores whose lines were taken away by coherence writebacks. A push queue holds line keys, which are the line tag joined with the history slot of the store that wrote the line. A commit drains the push queue as a stream of commands under a valid/ready handshake. Each command names a destination peer, and the peers are chosen in rotation.

Top module: `wsp_push_predictor`

## Requirements
- R1: After reset no command is offered, `st_busy`, `commit_done` and `drop_cnt` are 0 and `st_slot` is 0.
- R2: Every accepted store (`st_valid` while `st_busy` is low) writes its PC into history slot `st_slot`. `st_slot` then advances by one and wraps from 7 to 0.
- R3: A coherence writeback naming a history slot that holds a PC adds that PC to the watch list. Nothing changes if the PC is already listed or the slot has never been written. A full list replaces its oldest entry.
- R4: An accepted store whose PC is in the watch list appends the key {`st_tag`, `st_slot`} (tag in the upper bits) to the push queue. Nothing is added if that key is already queued. The lookup uses the watch list as it was before that clock edge.
- R5: When the push queue already holds 8 keys, a new distinct key is discarded and `drop_cnt` rises by one, saturating at its maximum.
- R6: After a `commit` pulse, each queued key is drained in insertion order as three commands: op 0 (write back), op 1 (self-invalidate), op 2 (push). Each command is presented on `cmd_line` with that key.
- R7: All three commands of one line carry the same `cmd_dest`. The destination moves to the next peer after each line, in ascending order with wrap, skipping `SELF_ID`. It starts at the first peer above `SELF_ID` after reset and carries over from one commit to the next.
- R8: `commit_done` is high for exactly one cycle. That cycle follows the acceptance of the last push, or follows the commit pulse when the queue is empty. The queue is empty afterwards.
- R9: `st_busy` is high from the cycle after the commit pulse through the `commit_done` cycle. Stores and commits offered while it is high are ignored.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op`, `cmd_line` and `cmd_dest` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store executes this cycle |
| st_pc | input | PC_W | PC of the store |
| st_tag | input | TAG_W | Address tag of the stored line |
| st_busy | output | 1 | Commit drain in progress; stores are not accepted |
| st_slot | output | log2(HIST_DEPTH) | History slot taken by a store accepted this cycle |
| cwb_valid | input | 1 | A coherence request forced a writeback of a line |
| cwb_slot | input | log2(HIST_DEPTH) | History slot kept with that line |
| commit | input | 1 | Thread commit pulse |
| cmd_valid | output | 1 | A drain command is offered |
| cmd_ready | input | 1 | Cache accepts the command |
| cmd_op | output | 2 | 0 write back, 1 self-invalidate, 2 push |
| cmd_line | output | TAG_W+log2(HIST_DEPTH) | Line key {tag, slot} |
| cmd_dest | output | log2(NUM_CPU) | Peer cache receiving the push |
| commit_done | output | 1 | One-cycle end-of-drain pulse |
| drop_cnt | output | DROP_W | Saturating count of discarded insertions |

## Verification
A wrong history slot or a stale watch-list entry changes which keys are queued. That error is hidden until the next commit, and then appears as a missing, extra or reordered command triple, so every drain is compared against a queue of expected commands. A stuck rotation pointer shows up on the second line of the first drain, because its destination repeats or names this processor. A broken full-queue guard shows up in `drop_cnt` right after a commit, and a store that leaks through the busy window shows up as a moved `st_slot` once the drain ends.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
   typedef enum logic [1:0] {
      OP_WBACK = 2'd0,
      OP_SINV  = 2'd1,
      OP_PUSH  = 2'd2
   } push_op_e;
endpackage

// File: rtl/wsp_store_hist.sv
module wsp_store_hist #(
   parameter int PC_W  = 16,
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   output logic [IW-1:0]   wr_ptr,
   input  logic [IW-1:0]   rd_idx,
   output logic [PC_W-1:0] rd_pc,
   output logic            rd_vld
);
   logic [PC_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0] vld;
   logic [IW-1:0]    wp;

   if ((1 << IW) != DEPTH) begin : g_depth_chk
      $error("store history depth must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         vld <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wp] <= wr_pc;
         vld[wp] <= 1'b1;
         wp      <= wp + 1'b1;
      end
   end

   assign wr_ptr = wp;
   assign rd_pc  = mem[rd_idx];
   assign rd_vld = vld[rd_idx];

   // R2
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> wp == IW'($past(wp) + 1'b1));
endmodule

// File: rtl/wsp_pc_watch.sv
module wsp_pc_watch #(
   parameter int PC_W  = 16,
   parameter int DEPTH = 8,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ins_en,
   input  logic [PC_W-1:0] ins_pc,
   input  logic [PC_W-1:0] look_pc,
   output logic            look_hit
);
   logic [PC_W-1:0]  mem [DEPTH];
   logic [DEPTH-1:0] vld;
   logic [IW-1:0]    wp;
   logic             ins_dup;

   always_comb begin
      look_hit = 1'b0;
      ins_dup  = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vld[i] && mem[i] == look_pc) look_hit = 1'b1;
         if (vld[i] && mem[i] == ins_pc)  ins_dup  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         vld <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (ins_en && !ins_dup) begin
         mem[wp] <= ins_pc;
         vld[wp] <= 1'b1;
         wp      <= (wp == IW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
   end

   // R3
   watch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld) == DEPTH |=> $countones(vld) == DEPTH);
   // R3
   watch_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en && ins_dup |=> $stable(wp));
endmodule

// File: rtl/wsp_push_buf.sv
module wsp_push_buf #(
   parameter int KW     = 15,
   parameter int DEPTH  = 8,
   parameter int DROP_W = 8,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_en,
   input  logic [KW-1:0]     ins_key,
   input  logic              clr,
   input  logic [IW-1:0]     rd_idx,
   output logic [KW-1:0]     rd_key,
   output logic [CW-1:0]     count,
   output logic [DROP_W-1:0] drop_cnt
);
   logic [KW-1:0] mem [DEPTH];
   logic [CW-1:0] cnt;
   logic          dup, full;

   always_comb begin
      dup = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (CW'(i) < cnt && mem[i] == ins_key) dup = 1'b1;
   end

   assign full   = (cnt == CW'(DEPTH));
   assign count  = cnt;
   assign rd_key = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         drop_cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (ins_en && !dup) begin
         if (!full) begin
            mem[cnt[IW-1:0]] <= ins_key;
            cnt              <= cnt + 1'b1;
         end else if (drop_cnt != '1) begin
            drop_cnt <= drop_cnt + 1'b1;
         end
      end
   end

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   // R5
   drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt != $past(drop_cnt) |-> $past(cnt) == CW'(DEPTH));
   // R8
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
endmodule

// File: rtl/wsp_drain_seq.sv
module wsp_drain_seq
   import wsp_pkg::*;
#(
   parameter int KW      = 15,
   parameter int DEPTH   = 8,
   parameter int NUM_CPU = 4,
   parameter int SELF_ID = 1,
   localparam int CW     = $clog2(DEPTH + 1),
   localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int PW     = $clog2(NUM_CPU)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic [CW-1:0] count,
   output logic [IW-1:0] rd_idx,
   input  logic [KW-1:0] rd_key,
   output logic          cmd_valid,
   input  logic          cmd_ready,
   output push_op_e      cmd_op,
   output logic [KW-1:0] cmd_key,
   output logic [PW-1:0] cmd_dest,
   output logic          busy,
   output logic          done,
   output logic          clr
);
   localparam logic [PW-1:0] SELF = PW'(SELF_ID);
   localparam logic [PW-1:0] LAST = PW'(NUM_CPU - 1);

   function automatic logic [PW-1:0] next_peer(input logic [PW-1:0] d);
      logic [PW-1:0] n;
      n = (d == LAST) ? '0 : d + 1'b1;
      if (n == SELF) n = (n == LAST) ? '0 : n + 1'b1;
      return n;
   endfunction

   logic          run;
   logic [CW-1:0] idx;
   push_op_e      phase;
   logic [PW-1:0] dest;

   assign busy      = run;
   assign cmd_valid = run && (idx < count);
   assign done      = run && (idx == count);
   assign clr       = done;
   assign rd_idx    = idx[IW-1:0];
   assign cmd_key   = rd_key;
   assign cmd_op    = phase;
   assign cmd_dest  = dest;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= 1'b0;
         idx   <= '0;
         phase <= OP_WBACK;
         dest  <= next_peer(SELF);
      end else if (!run) begin
         if (commit) begin
            run   <= 1'b1;
            idx   <= '0;
            phase <= OP_WBACK;
         end
      end else if (done) begin
         run <= 1'b0;
      end else if (cmd_valid && cmd_ready) begin
         case (phase)
            OP_WBACK: phase <= OP_SINV;
            OP_SINV:  phase <= OP_PUSH;
            default: begin
               phase <= OP_WBACK;
               idx   <= idx + 1'b1;
               dest  <= next_peer(dest);
            end
         endcase
      end
   end

   // R10
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_key) && $stable(cmd_dest));
   // R7
   dest_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_dest != SELF);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
   // R6
   op_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_op == OP_WBACK |=> cmd_op == OP_SINV);
endmodule

// File: rtl/wsp_push_predictor.sv
module wsp_push_predictor
   import wsp_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int TAG_W      = 12,
   parameter int HIST_DEPTH = 8,
   parameter int WATCH_DEPTH = 8,
   parameter int PUSH_DEPTH = 8,
   parameter int NUM_CPU    = 4,
   parameter int SELF_ID    = 1,
   parameter int DROP_W     = 8,
   localparam int SW        = $clog2(HIST_DEPTH),
   localparam int KW        = TAG_W + SW,
   localparam int PW        = $clog2(NUM_CPU),
   localparam int CW        = $clog2(PUSH_DEPTH + 1),
   localparam int QW        = (PUSH_DEPTH > 1) ? $clog2(PUSH_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [PC_W-1:0]   st_pc,
   input  logic [TAG_W-1:0]  st_tag,
   output logic              st_busy,
   output logic [SW-1:0]     st_slot,
   input  logic              cwb_valid,
   input  logic [SW-1:0]     cwb_slot,
   input  logic              commit,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_op,
   output logic [KW-1:0]     cmd_line,
   output logic [PW-1:0]     cmd_dest,
   output logic              commit_done,
   output logic [DROP_W-1:0] drop_cnt
);
   if (NUM_CPU < 2) begin : g_cpu_chk
      $error("at least two CPUs are needed for a peer");
   end
   if (SELF_ID < 0 || SELF_ID >= NUM_CPU) begin : g_self_chk
      $error("own CPU number out of range");
   end
   if (HIST_DEPTH < 2 || WATCH_DEPTH < 1 || PUSH_DEPTH < 1) begin : g_depth_chk
      $error("table depths too small");
   end

   logic            st_fire, watch_hit, hist_vld, drain_busy, drain_clr;
   logic [PC_W-1:0] hist_pc;
   logic [CW-1:0]   q_count;
   logic [QW-1:0]   q_rd_idx;
   logic [KW-1:0]   q_rd_key;
   push_op_e        op_e;

   assign st_fire = st_valid && !drain_busy;
   assign st_busy = drain_busy;
   assign cmd_op  = op_e;

   wsp_store_hist #(.PC_W(PC_W), .DEPTH(HIST_DEPTH)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .wr_en(st_fire), .wr_pc(st_pc), .wr_ptr(st_slot),
      .rd_idx(cwb_slot), .rd_pc(hist_pc), .rd_vld(hist_vld)
   );

   wsp_pc_watch #(.PC_W(PC_W), .DEPTH(WATCH_DEPTH)) u_watch (
      .clk(clk), .rst_n(rst_n),
      .ins_en(cwb_valid && hist_vld), .ins_pc(hist_pc),
      .look_pc(st_pc), .look_hit(watch_hit)
   );

   wsp_push_buf #(.KW(KW), .DEPTH(PUSH_DEPTH), .DROP_W(DROP_W)) u_pbuf (
      .clk(clk), .rst_n(rst_n),
      .ins_en(st_fire && watch_hit), .ins_key({st_tag, st_slot}),
      .clr(drain_clr), .rd_idx(q_rd_idx), .rd_key(q_rd_key),
      .count(q_count), .drop_cnt(drop_cnt)
   );

   wsp_drain_seq #(.KW(KW), .DEPTH(PUSH_DEPTH), .NUM_CPU(NUM_CPU), .SELF_ID(SELF_ID)) u_drain (
      .clk(clk), .rst_n(rst_n),
      .commit(commit), .count(q_count),
      .rd_idx(q_rd_idx), .rd_key(q_rd_key),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(op_e), .cmd_key(cmd_line), .cmd_dest(cmd_dest),
      .busy(drain_busy), .done(commit_done), .clr(drain_clr)
   );

   // R9
   busy_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_busy |=> $stable(st_slot));
   // R9
   busy_follows_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit && !st_busy |=> st_busy);
endmodule

// File: tb/sim_wsp_push_predictor.sv
module sim_wsp_push_predictor;
   localparam int PC_W = 16, TAG_W = 12, NCPU = 4, SELF = 1, SW = 3, KW = TAG_W + SW;

   logic clk = 0, rst_n = 0;
   logic st_valid = 0, cwb_valid = 0, commit = 0, cmd_ready = 1;
   logic [PC_W-1:0] st_pc = '0;
   logic [TAG_W-1:0] st_tag = '0;
   logic [SW-1:0] cwb_slot = '0;
   logic st_busy, cmd_valid, commit_done;
   logic [SW-1:0] st_slot;
   logic [1:0] cmd_op;
   logic [KW-1:0] cmd_line;
   logic [1:0] cmd_dest;
   logic [7:0] drop_cnt;

   always #5 clk = ~clk;

   wsp_push_predictor u0 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_pc(st_pc), .st_tag(st_tag),
      .st_busy(st_busy), .st_slot(st_slot), .cwb_valid(cwb_valid), .cwb_slot(cwb_slot),
      .commit(commit), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_line(cmd_line), .cmd_dest(cmd_dest), .commit_done(commit_done), .drop_cnt(drop_cnt)
   );

   int errors = 0, checks = 0;
   bit finished = 0;

   // reference model built from the requirements
   logic [PC_W-1:0] m_hist [8];
   bit              m_hv   [8];
   int              m_wp = 0;
   logic [PC_W-1:0] m_watch [8];
   bit              m_wv    [8];
   int              m_wwp = 0;
   logic [KW-1:0]   m_push [$];
   int              m_drop = 0;
   int              m_dest = 2;
   logic [KW+3:0]   exp_q [$];

   function automatic int nextp(input int d);
      int n = (d + 1) % NCPU;
      if (n == SELF) n = (n + 1) % NCPU;
      return n;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_store(input logic [PC_W-1:0] pc, input logic [TAG_W-1:0] tag);
      bit hit = 0, dup = 0;
      logic [KW-1:0] key;
      @(negedge clk);
      st_valid = 1; st_pc = pc; st_tag = tag; cwb_valid = 0;
      #1;
      chk(st_slot == SW'(m_wp), "R2 slot", st_slot, m_wp);
      for (int i = 0; i < 8; i++) if (m_wv[i] && m_watch[i] == pc) hit = 1;
      key = {tag, SW'(m_wp)};
      m_hist[m_wp] = pc; m_hv[m_wp] = 1; m_wp = (m_wp + 1) % 8;
      if (hit) begin
         foreach (m_push[i]) if (m_push[i] == key) dup = 1;
         if (!dup) begin
            if (m_push.size() < 8) m_push.push_back(key);
            else if (m_drop < 255) m_drop++;
         end
      end
   endtask

   task automatic do_cwb(input int slot);
      bit dup = 0;
      @(negedge clk);
      st_valid = 0; cwb_valid = 1; cwb_slot = SW'(slot);
      if (m_hv[slot]) begin
         for (int i = 0; i < 8; i++) if (m_wv[i] && m_watch[i] == m_hist[slot]) dup = 1;
         if (!dup) begin
            m_watch[m_wwp] = m_hist[slot]; m_wv[m_wwp] = 1; m_wwp = (m_wwp + 1) % 8;
         end
      end
   endtask

   task automatic do_commit(input bit try_store);
      bit got = 0;
      int slot_before;
      @(negedge clk);
      st_valid = 0; cwb_valid = 0; commit = 1;
      foreach (m_push[i]) begin
         for (int op = 0; op < 3; op++) exp_q.push_back({2'(op), m_push[i], 2'(m_dest)});
         m_dest = nextp(m_dest);
      end
      m_push.delete();
      slot_before = m_wp;
      @(negedge clk);
      commit = 0;
      chk(st_busy == 1, "R9 busy after commit", st_busy, 1);
      for (int k = 0; k < 400; k++) begin
         if (try_store && k == 1) begin st_valid = 1; st_pc = 16'h0077; st_tag = 12'hABC; commit = 1; end
         if (k == 2) begin st_valid = 0; commit = 0; end
         if (commit_done) begin got = 1; break; end
         @(negedge clk);
      end
      st_valid = 0; commit = 0;
      chk(got, "R8 commit_done seen", got, 1);
      chk(exp_q.size() == 0, "R6 all commands drained", exp_q.size(), 0);
      @(negedge clk);
      chk(commit_done == 0, "R8 done one cycle", commit_done, 0);
      chk(st_busy == 0, "R9 busy cleared", st_busy, 0);
      chk(cmd_valid == 0, "R8 queue empty", cmd_valid, 0);
      chk(st_slot == SW'(slot_before), "R9 store ignored while busy", st_slot, slot_before);
      chk(drop_cnt == 8'(m_drop), "R5 drop count", drop_cnt, m_drop);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cmd_valid && cmd_ready) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R6 unexpected command actual=%0h expected=none", {cmd_op, cmd_line, cmd_dest});
         end else begin
            logic [KW+3:0] e;
            e = exp_q.pop_front();
            chk({cmd_op, cmd_line, cmd_dest} == e, "R6/R7 command op,line,dest", {cmd_op, cmd_line, cmd_dest}, e);
         end
      end
   end

   // backpressure, changed away from both sampling and active edges (R10 exercised)
   int rcnt = 0;
   always @(posedge clk) begin
      #2;
      rcnt++;
      cmd_ready = (rcnt % 4 != 3);
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int lf = 32'h1234_5678;
      for (int i = 0; i < 8; i++) begin m_hv[i] = 0; m_wv[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      // R1 reset state
      chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
      chk(st_busy == 0, "R1 st_busy", st_busy, 0);
      chk(commit_done == 0, "R1 commit_done", commit_done, 0);
      chk(drop_cnt == 0, "R1 drop_cnt", drop_cnt, 0);
      chk(st_slot == 0, "R1 st_slot", st_slot, 0);

      // R8 empty commit
      do_commit(0);

      // R3 unwritten slot ignored, duplicate PC ignored
      do_cwb(5);
      do_store(16'h0077, 12'h001);
      do_cwb(0);
      do_cwb(0);
      do_store(16'h0077, 12'h002);   // R4 hit
      do_store(16'h0200, 12'h003);   // no hit
      for (int i = 0; i < 5; i++) do_store(16'h0300 + 16'(i), 12'h010);
      do_store(16'h0077, 12'h001);   // slot 0 again, new key
      do_store(16'h0077, 12'h002);   // slot 1 again: duplicate key (R4)
      do_commit(0);

      // R5 fill queue beyond capacity, then blocked store/commit during drain (R9)
      for (int i = 0; i < 11; i++) do_store(16'h0077, 12'h100 + 12'(i));
      do_commit(1);

      // mixed traffic, R3 FIFO replacement and R7 rotation across commits
      for (int r = 0; r < 8; r++) begin
         for (int n = 0; n < 40; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            if ((lf & 3) == 3) do_cwb((lf >> 4) & 7);
            else do_store(16'h0040 + 16'((lf >> 8) % 11), 12'((lf >> 16) & 15));
         end
         do_commit(r[0]);
      end
      finish_run();
   end
endmodule